// File: doc/BRIEF.md
# Inter-Engine Dependency Token Gate

This block orders the work of three pipelined engines: a loader, a compute engine and a storer. The engines are linked by four one-bit token queues: loader to compute, compute to loader, compute to storer and storer to compute. Every instruction an engine wants to run carries four dependency flags. Two of them name the tokens it must consume before it starts, one from the previous neighbour and one from the next. The other two name the tokens it must produce after it ends, one to each neighbour. The neighbours are fixed by the pipeline. The loader has no previous neighbour and the storer has no next neighbour, so those flags reach no queue.

An engine raises a start request with the flags of its next instruction and a finish marker. The gate grants the start only when every queue the instruction must consume from holds a token. It then takes all of those tokens in the same cycle. The gate keeps the produce flags and the finish marker of the granted instruction. When the engine later reports completion, the gate deposits the requested tokens and acknowledges. If a target queue is full, the gate holds the acknowledge back until space frees up. Completing an instruction marked finish sets a sticky finished flag. A synchronous clear drops that flag, empties every queue and forgets any instruction that is still outstanding. The block does not execute instructions.

Top module: `dep_token_gate`

## Requirements
- R1: After reset, every token queue is empty, no start grant and no completion acknowledge is asserted, and the finished flag is low.
- R2: An engine's start grant is asserted combinationally in the cycle of its start request when that engine has no outstanding instruction and every queue the instruction must consume from is non-empty. The tokens are removed at the clock edge that ends that cycle. Engine index: 0 = loader, 1 = compute, 2 = storer. Lane e of start_flags is bits [4e+3:4e]: bit 0 consume-previous, bit 1 consume-next, bit 2 produce-previous, bit 3 produce-next.
- R3: If any required queue is empty, the grant stays low and no token is taken from any queue, including the queues that are non-empty.
- R4: Consume routing: compute-previous uses loader→compute, compute-next uses storer→compute, loader-next uses compute→loader, and storer-previous uses compute→storer.
- R5: Produce routing, applied only at the acknowledged completion and using the flags latched at grant: compute-previous feeds compute→loader, compute-next feeds compute→storer, loader-next feeds loader→compute, and storer-previous feeds storer→compute.
- R6: Loader consume-previous and produce-previous, and storer consume-next and produce-next, touch no queue and never block a grant or an acknowledge.
- R7: Each engine has at most one outstanding instruction. While an instruction is outstanding, a start request is not granted. A completion request from an engine with nothing outstanding is not acknowledged.
- R8: Each queue holds up to 8 tokens. A completion that would produce into a full queue is held unacknowledged, and it is acknowledged in the first cycle after that queue has room.
- R9: A consume and a produce on the same queue in the same cycle both take effect, and the token count is unchanged.
- R10: The finished flag rises in the cycle after a completion acknowledge of an instruction that was started with start_fin high. It does not rise at the grant, and it stays high until a clear.
- R11: While clr is high, no grant or acknowledge is given. After clr, all queues are empty, the finished flag is low and no instruction is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Synchronous clear of queues, outstanding state and finished flag |
| start_req | input | 3 | Per-engine start request |
| start_flags | input | 12 | Per-engine dependency flags, 4 bits per engine |
| start_fin | input | 3 | Per-engine finish marker of the requesting instruction |
| start_grant | output | 3 | Per-engine start grant, same cycle as the request |
| done_req | input | 3 | Per-engine completion request |
| done_ack | output | 3 | Per-engine completion acknowledge, same cycle as the request |
| fin_flag | output | 1 | Sticky finished flag |

## Verification
The assertions assume that an engine keeps start_req and done_req asserted until it sees its grant or acknowledge. They also assume that each queue has only one producer engine and one consumer engine, which the fixed routing ensures. The bench holds every request for a single cycle when it expects a stall. When it expects a wait, as with a full queue, it holds the request in place, and it changes inputs only on falling edges. The bench observes the queue contents only through later grants, so every claim about emptiness or count is confirmed by a series of start attempts.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int NUM_ENG = 3;
  localparam int NUM_Q   = 4;
  localparam int FW      = 4;

  localparam int ENG_LOAD  = 0;
  localparam int ENG_COMP  = 1;
  localparam int ENG_STORE = 2;

  localparam int Q_L2C = 0;
  localparam int Q_C2L = 1;
  localparam int Q_C2S = 2;
  localparam int Q_S2C = 3;

  typedef struct packed {
    logic push_next;
    logic push_prev;
    logic pop_next;
    logic pop_prev;
  } dep_flags_t;

  function automatic logic [NUM_Q-1:0] pop_route(int eng, dep_flags_t f);
    logic [NUM_Q-1:0] m;
    m = '0;
    case (eng)
      ENG_LOAD:  m[Q_C2L] = f.pop_next;
      ENG_COMP: begin
        m[Q_L2C] = f.pop_prev;
        m[Q_S2C] = f.pop_next;
      end
      default:   m[Q_C2S] = f.pop_prev;
    endcase
    return m;
  endfunction

  function automatic logic [NUM_Q-1:0] push_route(int eng, dep_flags_t f);
    logic [NUM_Q-1:0] m;
    m = '0;
    case (eng)
      ENG_LOAD:  m[Q_L2C] = f.push_next;
      ENG_COMP: begin
        m[Q_C2L] = f.push_prev;
        m[Q_C2S] = f.push_next;
      end
      default:   m[Q_S2C] = f.push_prev;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/dtg_rst_sync.sv
module dtg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dtg_token_counter.sv
module dtg_token_counter #(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic push,
  input  logic pop,
  output logic avail,
  output logic room
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [CW-1:0] count_q, count_d;
  logic          count_en;

  always_comb begin
    count_en = clr | push | pop;
    count_d  = count_q;
    if (clr) begin
      count_d = '0;
    end else begin
      case ({push, pop})
        2'b10:   count_d = count_q + 1'b1;
        2'b01:   count_d = count_q - 1'b1;
        default: count_d = count_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  assign avail = (count_q != '0);
  assign room  = (count_q != FULL);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> count_q != FULL);
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count_q != '0);
  assert_push_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !clr) |=> count_q == $past(count_q) + 1'b1);
  assert_pair_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !clr) |=> $stable(count_q));
endmodule

// File: rtl/dtg_engine_port.sv
module dtg_engine_port
  import dtg_pkg::*;
#(
  parameter int ENG_ID = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             req,
  input  dep_flags_t       flags,
  input  logic             fin,
  input  logic             done_req,
  input  logic [NUM_Q-1:0] q_avail,
  input  logic [NUM_Q-1:0] q_room,
  output logic             grant,
  output logic             ack,
  output logic [NUM_Q-1:0] pop_vec,
  output logic [NUM_Q-1:0] push_vec,
  output logic             fin_done
);
  logic             busy_q, busy_d;
  logic [NUM_Q-1:0] push_mask_q;
  logic             fin_q;
  logic [NUM_Q-1:0] pop_need;
  logic             pops_ok, pushes_ok;

  always_comb begin
    pop_need  = pop_route(ENG_ID, flags);
    pops_ok   = ((pop_need & ~q_avail) == '0);
    pushes_ok = ((push_mask_q & ~q_room) == '0);
    grant     = req & ~busy_q & pops_ok & ~clr;
    ack       = done_req & busy_q & pushes_ok & ~clr;
    pop_vec   = grant ? pop_need : '0;
    push_vec  = ack ? push_mask_q : '0;
    fin_done  = ack & fin_q;
    if (clr)        busy_d = 1'b0;
    else if (grant) busy_d = 1'b1;
    else if (ack)   busy_d = 1'b0;
    else            busy_d = busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      push_mask_q <= '0;
      fin_q       <= 1'b0;
    end else if (grant) begin
      push_mask_q <= push_route(ENG_ID, flags);
      fin_q       <= fin;
    end
  end

  assert_grant_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> busy_q);
  assert_no_regrant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !grant);
  assert_ack_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !busy_q);
  assert_clr_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !busy_q);
endmodule

// File: rtl/dep_token_gate.sv
module dep_token_gate
  import dtg_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic [NUM_ENG-1:0]    start_req,
  input  logic [NUM_ENG*FW-1:0] start_flags,
  input  logic [NUM_ENG-1:0]    start_fin,
  output logic [NUM_ENG-1:0]    start_grant,
  input  logic [NUM_ENG-1:0]    done_req,
  output logic [NUM_ENG-1:0]    done_ack,
  output logic                  fin_flag
);
  logic rst_sync_n;

  logic [NUM_Q-1:0]   q_avail, q_room;
  logic [NUM_Q-1:0]   pop_vec  [NUM_ENG];
  logic [NUM_Q-1:0]   push_vec [NUM_ENG];
  logic [NUM_ENG-1:0] fin_done;
  logic [NUM_Q-1:0]   q_pop, q_push;
  logic               fin_d, fin_en;

  dtg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar e = 0; e < NUM_ENG; e++) begin : g_eng
    dtg_engine_port #(.ENG_ID(e)) u_port (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .clr      (clr),
      .req      (start_req[e]),
      .flags    (dep_flags_t'(start_flags[e*FW +: FW])),
      .fin      (start_fin[e]),
      .done_req (done_req[e]),
      .q_avail  (q_avail),
      .q_room   (q_room),
      .grant    (start_grant[e]),
      .ack      (done_ack[e]),
      .pop_vec  (pop_vec[e]),
      .push_vec (push_vec[e]),
      .fin_done (fin_done[e])
    );
  end

  always_comb begin
    q_pop  = '0;
    q_push = '0;
    for (int e = 0; e < NUM_ENG; e++) begin
      q_pop  = q_pop  | pop_vec[e];
      q_push = q_push | push_vec[e];
    end
  end

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    dtg_token_counter #(.DEPTH(DEPTH)) u_cnt (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .clr   (clr),
      .push  (q_push[q]),
      .pop   (q_pop[q]),
      .avail (q_avail[q]),
      .room  (q_room[q])
    );
  end

  always_comb begin
    fin_en = clr | (|fin_done);
    fin_d  = ~clr;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  fin_flag <= 1'b0;
    else if (fin_en)  fin_flag <= fin_d;
  end

  assert_fin_sticky_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (fin_flag && !clr) |=> fin_flag);
  assert_fin_cause_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(fin_flag) |-> $past(|done_ack));
  assert_clr_empty_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clr |=> (q_avail == '0) && !fin_flag);
endmodule

// File: tb/dep_token_gate_bench.sv
`timescale 1ns/1ps
module dep_token_gate_bench;
  localparam int E_L = 0, E_C = 1, E_S = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        clr;
  logic [2:0]  start_req;
  logic [11:0] start_flags;
  logic [2:0]  start_fin;
  logic [2:0]  start_grant;
  logic [2:0]  done_req;
  logic [2:0]  done_ack;
  logic        fin_flag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dep_token_gate u_dep_token_gate (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .start_req(start_req), .start_flags(start_flags), .start_fin(start_fin),
    .start_grant(start_grant), .done_req(done_req), .done_ack(done_ack),
    .fin_flag(fin_flag)
  );

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic start_try(int e, logic [3:0] f, logic fn, logic exp, string tag);
    @(negedge clk);
    start_req[e] = 1'b1;
    start_flags[4*e +: 4] = f;
    start_fin[e] = fn;
    #1 check(tag, start_grant[e], exp);
    @(posedge clk);
    #1;
    start_req[e] = 1'b0;
    start_fin[e] = 1'b0;
    start_flags[4*e +: 4] = 4'b0;
  endtask

  task automatic finish_try(int e, logic exp, string tag);
    @(negedge clk);
    done_req[e] = 1'b1;
    #1 check(tag, done_ack[e], exp);
    @(posedge clk);
    #1 done_req[e] = 1'b0;
  endtask

  task automatic run_insn(int e, logic [3:0] f, string tag);
    start_try(e, f, 1'b0, 1'b1, tag);
    finish_try(e, 1'b1, tag);
  endtask

  task automatic clear_all();
    @(negedge clk);
    clr = 1'b1;
    @(posedge clk);
    #1 clr = 1'b0;
  endtask

  task automatic expect_all_empty(string tag);
    start_try(E_C, 4'b0001, 1'b0, 1'b0, {tag, " l2c empty"});
    start_try(E_C, 4'b0010, 1'b0, 1'b0, {tag, " s2c empty"});
    start_try(E_L, 4'b0010, 1'b0, 1'b0, {tag, " c2l empty"});
    start_try(E_S, 4'b0001, 1'b0, 1'b0, {tag, " c2s empty"});
  endtask

  task automatic t_reset();
    check("R1 grant idle", |start_grant, 1'b0);
    check("R1 ack idle", |done_ack, 1'b0);
    check("R1 fin low", fin_flag, 1'b0);
    expect_all_empty("R1");
  endtask

  task automatic t_ignored();
    clear_all();
    start_try(E_L, 4'b0101, 1'b0, 1'b1, "R6 load prev flags grant");
    finish_try(E_L, 1'b1, "R6 load prev push ack");
    start_try(E_S, 4'b1010, 1'b0, 1'b1, "R6 store next flags grant");
    finish_try(E_S, 1'b1, "R6 store next push ack");
    expect_all_empty("R6");
  endtask

  task automatic t_routing();
    clear_all();
    run_insn(E_L, 4'b1000, "R5 load push next");
    start_try(E_C, 4'b1101, 1'b0, 1'b1, "R4 compute pops l2c");
    finish_try(E_C, 1'b1, "R5 compute pushes c2l c2s");
    start_try(E_S, 4'b0101, 1'b0, 1'b1, "R4 store pops c2s");
    finish_try(E_S, 1'b1, "R5 store pushes s2c");
    start_try(E_C, 4'b0011, 1'b0, 1'b0, "R3 compute stalls l2c empty");
    start_try(E_L, 4'b1010, 1'b0, 1'b1, "R4 load pops c2l");
    finish_try(E_L, 1'b1, "R5 load pushes l2c");
    start_try(E_C, 4'b0011, 1'b0, 1'b1, "R3 s2c kept after stall");
    finish_try(E_C, 1'b1, "R2 compute ack");
    expect_all_empty("R2 tokens consumed");
  endtask

  task automatic t_outstanding();
    clear_all();
    start_try(E_L, 4'b0000, 1'b0, 1'b1, "R2 plain grant");
    start_try(E_L, 4'b0000, 1'b0, 1'b0, "R7 no grant while busy");
    finish_try(E_L, 1'b1, "R7 ack busy");
    finish_try(E_L, 1'b0, "R7 no ack when idle");
    finish_try(E_C, 1'b0, "R7 compute no ack idle");
  endtask

  task automatic t_full();
    clear_all();
    for (int i = 0; i < 8; i++) run_insn(E_L, 4'b1000, "R8 fill");
    start_try(E_L, 4'b1000, 1'b0, 1'b1, "R8 ninth grant");
    @(negedge clk);
    done_req[E_L] = 1'b1;
    #1 check("R8 held when full", done_ack[E_L], 1'b0);
    @(negedge clk);
    start_req[E_C] = 1'b1;
    start_flags[4*E_C +: 4] = 4'b0001;
    #1;
    check("R8 pop while full", start_grant[E_C], 1'b1);
    check("R8 still held", done_ack[E_L], 1'b0);
    @(posedge clk);
    #1 start_req[E_C] = 1'b0;
    @(negedge clk);
    #1 check("R8 ack after room", done_ack[E_L], 1'b1);
    @(posedge clk);
    #1 done_req[E_L] = 1'b0;
    finish_try(E_C, 1'b1, "R8 compute ack");
    run_insn(E_C, 4'b0001, "R9 drop to seven");
    start_try(E_L, 4'b1000, 1'b0, 1'b1, "R9 load grant");
    @(negedge clk);
    done_req[E_L] = 1'b1;
    start_req[E_C] = 1'b1;
    start_flags[4*E_C +: 4] = 4'b0001;
    #1;
    check("R9 push ack", done_ack[E_L], 1'b1);
    check("R9 pop grant", start_grant[E_C], 1'b1);
    @(posedge clk);
    #1;
    done_req[E_L] = 1'b0;
    start_req[E_C] = 1'b0;
    finish_try(E_C, 1'b1, "R9 compute ack");
    for (int i = 0; i < 7; i++) run_insn(E_C, 4'b0001, "R9 drain seven");
    start_try(E_C, 4'b0001, 1'b0, 1'b0, "R9 empty after seven");
  endtask

  task automatic t_finish_clear();
    clear_all();
    start_try(E_S, 4'b0000, 1'b1, 1'b1, "R10 fin grant");
    check("R10 not set at grant", fin_flag, 1'b0);
    finish_try(E_S, 1'b1, "R10 fin ack");
    check("R10 set after ack", fin_flag, 1'b1);
    repeat (3) @(posedge clk);
    #1 check("R10 sticky", fin_flag, 1'b1);
    run_insn(E_L, 4'b1000, "R11 token before clear");
    start_try(E_C, 4'b0000, 1'b0, 1'b1, "R11 compute outstanding");
    @(negedge clk);
    clr = 1'b1;
    start_req[E_L] = 1'b1;
    #1 check("R11 no grant during clr", start_grant[E_L], 1'b0);
    @(posedge clk);
    #1;
    clr = 1'b0;
    start_req[E_L] = 1'b0;
    check("R11 fin cleared", fin_flag, 1'b0);
    finish_try(E_C, 1'b0, "R11 outstanding dropped");
    expect_all_empty("R11");
  endtask

  initial begin
    rst_n = 1'b0;
    clr = 1'b0;
    start_req = '0;
    start_flags = '0;
    start_fin = '0;
    done_req = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_ignored();
    t_routing();
    t_outstanding();
    t_full();
    t_finish_clear();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule